// File: doc/BRIEF.md
# Dual-Width Host Bus Slave Interface

This block connects a character display core to a host processor that talks over an asynchronous strobe bus. The bus has a register-select line, a read/write line, an enable strobe and an eight-bit data path, split here into an input half and an output half with an output enable so that a pad ring can build the tri-state driver. The enable strobe and everything it qualifies are passed through a two-flop synchroniser. A transfer is taken when the synchronised enable falls, using the values seen while it was high.

The host can move whole bytes or move each byte as two nibbles on the upper four lines, high nibble first. The width is switched at run time by the data-length bit of the function-set instruction, which the block watches in the instruction bytes it assembles. Completed writes reach the core as one-cycle instruction or data strobes carrying the byte. Reads return a status byte (busy flag on the top bit, address counter below it) or a data byte from the core. A strobe marks each completed data read so that the core can step its address.

Top module: `hostbus_if`

## Requirements
- R1: After reset the interface is in 8-bit mode (`wide_mode`=1), `bus_oe` is 0, `bus_dout` is 0 and no strobe is raised.
- R2: A completed write with `bus_sel`=0 raises `instr_valid` for one cycle, and one with `bus_sel`=1 raises `data_valid` for one cycle. In both cases `wr_byte` holds the byte from that cycle on.
- R3: A transfer is captured from the values present while enable was high. This holds when enable stays high and low for as few as 3 clock cycles each, and when the data lines change in the same cycle that enable falls.
- R4: In 4-bit mode a byte takes two transfers: the first carries bits 7:4 on `bus_din[7:4]`, the second bits 3:0 on `bus_din[7:4]`. `bus_din[3:0]` is ignored, and no strobe is raised after the first transfer.
- R5: An instruction byte whose bits 7:5 are 001 sets the mode from its bit 4 (1 = 8-bit, 0 = 4-bit), taking effect from the next transfer. The mode changes on no other event.
- R6: A read with `bus_sel`=0 returns the status byte {`core_busy`, `core_ac[6:0]`}. In 4-bit mode the high nibble, then the low nibble, appears on `bus_dout[7:4]` with `bus_dout[3:0]`=0.
- R7: A read with `bus_sel`=1 returns `core_rd_data`, arranged as in R6. `rd_done` pulses for one cycle after the last transfer of the byte, and status reads never pulse it.
- R8: `bus_oe` is high only while a read transfer's synchronised enable is high. It is low during writes and idle, and `bus_dout` is 0 whenever `bus_oe` is low.
- R9: `instr_valid`, `data_valid` and `rd_done` are never high together, and each follows the end of a transfer.
- R10: Reset clears the nibble phase, so a byte begun before reset does not combine with nibbles sent after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register select: 0 instruction/status, 1 data |
| bus_rd | input | 1 | 1 read, 0 write |
| bus_en | input | 1 | Asynchronous transfer strobe |
| bus_din | input | 8 | Data lines from host |
| bus_dout | output | 8 | Data lines toward host |
| bus_oe | output | 1 | Output enable for the data pads |
| core_busy | input | 1 | Core busy flag for status reads |
| core_ac | input | 7 | Core address counter for status reads |
| core_rd_data | input | 8 | Byte the core offers for data reads |
| instr_valid | output | 1 | Instruction byte written (one cycle) |
| data_valid | output | 1 | Data byte written (one cycle) |
| rd_done | output | 1 | Data byte read completed (one cycle) |
| wr_byte | output | 8 | Last written byte |
| wide_mode | output | 1 | 1 = 8-bit mode, 0 = 4-bit mode |

## Verification
Directed sequences cover minimum-length strobes with the data changing as enable falls, a switch into 4-bit mode, status and data reads in both widths, and a reset taken between the two nibbles. These separate a correct capture point from late sampling, a correct nibble order from a swapped one, and a cleared phase from a stale one. Random mixes of instruction writes, data writes, status reads and data reads then follow, using random busy, address and read values. Some of the random instructions switch the width, so both widths are exercised against a bench model of the mode.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
    localparam int DW      = 8;
    localparam int NIB     = DW / 2;
    localparam int ACW     = DW - 1;
    localparam int FS_W    = 3;
    localparam logic [FS_W-1:0] FS_CODE = 3'b001;
    localparam int DL_BIT  = 4;
    localparam int SMP_W   = DW + 2;

    typedef struct packed {
        logic          sel;
        logic          rd;
        logic [DW-1:0] d;
    } bus_smp_t;

    typedef struct packed {
        logic           prev;
        bus_smp_t       hold;
        logic           nib;
        logic [NIB-1:0] hi;
        logic           wide;
        logic           iv;
        logic           dv;
        logic           rdn;
        logic [DW-1:0]  wbyte;
    } rx_st_t;

    typedef struct packed {
        logic          oe;
        logic          half;
        logic [DW-1:0] obyte;
    } tx_st_t;
endpackage

// File: rtl/hbi_sync.sv
module hbi_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] meta_d, meta_q, sync_d, sync_q;

    always_comb begin
        meta_d = din;
        sync_d = meta_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= meta_d;
            sync_q <= sync_d;
        end
    end

    assign dout = sync_q;
endmodule

// File: rtl/hbi_rx.sv
module hbi_rx
    import hbi_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_s,
    input  bus_smp_t      smp_s,
    output logic          rise,
    output logic          fall,
    output logic          nib_phase,
    output logic          wide,
    output logic          iv,
    output logic          dv,
    output logic          rdn,
    output logic [DW-1:0] wbyte
);
    rx_st_t st_d, st_q;
    logic          done;
    logic [DW-1:0] full;

    always_comb begin
        st_d       = st_q;
        st_d.prev  = en_s;
        st_d.iv    = 1'b0;
        st_d.dv    = 1'b0;
        st_d.rdn   = 1'b0;
        rise       = en_s & ~st_q.prev;
        fall       = ~en_s & st_q.prev;
        done       = 1'b0;
        full       = st_q.hold.d;

        if (en_s)
            st_d.hold = smp_s;

        if (fall) begin
            if (st_q.wide) begin
                done = 1'b1;
                full = st_q.hold.d;
            end else if (!st_q.nib) begin
                st_d.hi  = st_q.hold.d[DW-1:NIB];
                st_d.nib = 1'b1;
            end else begin
                done     = 1'b1;
                full     = {st_q.hi, st_q.hold.d[DW-1:NIB]};
                st_d.nib = 1'b0;
            end
        end

        if (done) begin
            if (!st_q.hold.rd) begin
                st_d.wbyte = full;
                if (st_q.hold.sel) begin
                    st_d.dv = 1'b1;
                end else begin
                    st_d.iv = 1'b1;
                    if (full[DW-1 -: FS_W] == FS_CODE)
                        st_d.wide = full[DL_BIT];
                end
            end else if (st_q.hold.sel) begin
                st_d.rdn = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.wide <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign nib_phase = st_q.nib;
    assign wide      = st_q.wide;
    assign iv        = st_q.iv;
    assign dv        = st_q.dv;
    assign rdn       = st_q.rdn;
    assign wbyte     = st_q.wbyte;
endmodule

// File: rtl/hbi_tx.sv
module hbi_tx
    import hbi_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rise,
    input  logic           en_s,
    input  logic           sel_s,
    input  logic           rd_s,
    input  logic           nib_phase,
    input  logic           wide,
    input  logic           busy,
    input  logic [ACW-1:0] ac,
    input  logic [DW-1:0]  rd_data,
    output logic           oe,
    output logic [DW-1:0]  dout
);
    tx_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rise && rd_s) begin
            st_d.oe   = 1'b1;
            st_d.half = wide ? 1'b0 : nib_phase;
            if (wide || !nib_phase)
                st_d.obyte = sel_s ? rd_data : {busy, ac};
        end
        if (!en_s)
            st_d.oe = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        dout = '0;
        if (st_q.oe) begin
            if (wide)
                dout = st_q.obyte;
            else if (st_q.half)
                dout = {st_q.obyte[NIB-1:0], {NIB{1'b0}}};
            else
                dout = {st_q.obyte[DW-1:NIB], {NIB{1'b0}}};
        end
    end

    assign oe = st_q.oe;
endmodule

// File: rtl/hostbus_if.sv
module hostbus_if
    import hbi_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_sel,
    input  logic           bus_rd,
    input  logic           bus_en,
    input  logic [DW-1:0]  bus_din,
    output logic [DW-1:0]  bus_dout,
    output logic           bus_oe,
    input  logic           core_busy,
    input  logic [ACW-1:0] core_ac,
    input  logic [DW-1:0]  core_rd_data,
    output logic           instr_valid,
    output logic           data_valid,
    output logic           rd_done,
    output logic [DW-1:0]  wr_byte,
    output logic           wide_mode
);
    logic [SMP_W:0] raw, synced;
    logic           en_s, rd_s, rx_rise, rx_fall, nib_phase;
    bus_smp_t       smp_s;

    assign raw = {bus_en, bus_sel, bus_rd, bus_din};

    hbi_sync #(.W(SMP_W + 1)) u_sync (
        .clk (clk),
        .rst_n (rst_n),
        .din (raw),
        .dout (synced)
    );

    assign en_s  = synced[SMP_W];
    assign smp_s = synced[SMP_W-1:0];
    assign rd_s  = smp_s.rd;

    hbi_rx u_rx (
        .clk (clk),
        .rst_n (rst_n),
        .en_s (en_s),
        .smp_s (smp_s),
        .rise (rx_rise),
        .fall (rx_fall),
        .nib_phase (nib_phase),
        .wide (wide_mode),
        .iv (instr_valid),
        .dv (data_valid),
        .rdn (rd_done),
        .wbyte (wr_byte)
    );

    hbi_tx u_tx (
        .clk (clk),
        .rst_n (rst_n),
        .rise (rx_rise),
        .en_s (en_s),
        .sel_s (smp_s.sel),
        .rd_s (rd_s),
        .nib_phase (nib_phase),
        .wide (wide_mode),
        .busy (core_busy),
        .ac (core_ac),
        .rd_data (core_rd_data),
        .oe (bus_oe),
        .dout (bus_dout)
    );
endmodule

// File: rtl/hbi_chk.sv
module hbi_chk
    import hbi_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          en_s,
    input logic          rd_s,
    input logic          rx_fall,
    input logic          bus_oe,
    input logic [DW-1:0] bus_dout,
    input logic          wide_mode,
    input logic          instr_valid,
    input logic          data_valid,
    input logic          rd_done
);
    a_r8_oe_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> $past(rd_s));

    a_r8_oe_drops_with_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !en_s |=> !bus_oe);

    a_r9_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({instr_valid, data_valid, rd_done}));

    a_r9_strobe_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid || data_valid || rd_done) |-> $past(rx_fall));

    a_r6_low_lines_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_mode |-> (bus_dout[NIB-1:0] == '0));

    a_r5_mode_only_by_instr: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wide_mode) |-> instr_valid);
endmodule

bind hostbus_if hbi_chk u_chk (
    .clk (clk),
    .rst_n (rst_n),
    .en_s (en_s),
    .rd_s (rd_s),
    .rx_fall (rx_fall),
    .bus_oe (bus_oe),
    .bus_dout (bus_dout),
    .wide_mode (wide_mode),
    .instr_valid (instr_valid),
    .data_valid (data_valid),
    .rd_done (rd_done)
);

// File: tb/hostbus_if_tb.sv
module hostbus_if_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 0, rst_n = 0;
    logic       bus_sel = 0, bus_rd = 0, bus_en = 0;
    logic [7:0] bus_din = 0, bus_dout, core_rd_data = 0, wr_byte;
    logic       bus_oe, core_busy = 0, instr_valid, data_valid, rd_done, wide_mode;
    logic [6:0] core_ac = 0;

    int total = 0, bad = 0;
    int n_iv = 0, n_dv = 0, n_rd = 0;
    bit m_wide = 1;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hostbus_if u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_en(bus_en),
        .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe), .core_busy(core_busy),
        .core_ac(core_ac), .core_rd_data(core_rd_data), .instr_valid(instr_valid),
        .data_valid(data_valid), .rd_done(rd_done), .wr_byte(wr_byte), .wide_mode(wide_mode)
    );

    always @(negedge clk) begin
        if (instr_valid) n_iv++;
        if (data_valid)  n_dv++;
        if (rd_done)     n_rd++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic s, input logic r, input logic [7:0] d, input int hi,
                        output logic [7:0] got, output logic goe);
        @(negedge clk); bus_sel = s; bus_rd = r; bus_din = d;
        @(negedge clk); bus_en = 1;
        repeat (hi) @(negedge clk);
        got = bus_dout; goe = bus_oe;
        bus_en = 0; bus_din = 8'($urandom);
        repeat (5) @(negedge clk);
    endtask

    function automatic bit is_fs(input logic [7:0] b);
        return b[7:5] == 3'b001;
    endfunction

    task automatic write_byte(input logic s, input logic [7:0] b, input int hi);
        logic [7:0] g; logic o;
        int iv0 = n_iv, dv0 = n_dv;
        if (m_wide) begin
            xfer(s, 0, b, hi, g, o);
        end else begin
            xfer(s, 0, {b[7:4], 4'($urandom)}, hi, g, o);
            chk(n_iv == iv0 && n_dv == dv0, "R4 no strobe after first nibble", n_iv + n_dv, iv0 + dv0);
            xfer(s, 0, {b[3:0], 4'($urandom)}, hi, g, o);
        end
        chk(o == 0, "R8 oe low on write", o, 0);
        if (s) chk(n_dv == dv0 + 1 && n_iv == iv0, "R2 data strobe", n_dv, dv0 + 1);
        else   chk(n_iv == iv0 + 1 && n_dv == dv0, "R2 instr strobe", n_iv, iv0 + 1);
        chk(wr_byte == b, "R2 wr_byte", wr_byte, b);
        if (!s && is_fs(b)) m_wide = b[4];
        chk(wide_mode == m_wide, "R5 mode", wide_mode, m_wide);
    endtask

    task automatic read_byte(input logic s, input logic [7:0] exp);
        logic [7:0] g; logic o;
        int rd0 = n_rd;
        if (m_wide) begin
            xfer(s, 1, 8'($urandom), 5, g, o);
            chk(g == exp && o, s ? "R7 data read" : "R6 status read", g, exp);
        end else begin
            xfer(s, 1, 8'($urandom), 5, g, o);
            chk(g == {exp[7:4], 4'h0} && o, s ? "R7 data hi nibble" : "R6 status hi nibble", g, {exp[7:4], 4'h0});
            chk(n_rd == rd0, "R7 no rd_done mid byte", n_rd, rd0);
            xfer(s, 1, 8'($urandom), 5, g, o);
            chk(g == {exp[3:0], 4'h0} && o, s ? "R7 data lo nibble" : "R6 status lo nibble", g, {exp[3:0], 4'h0});
        end
        chk(n_rd == rd0 + (s ? 1 : 0), "R7 rd_done count", n_rd, rd0 + (s ? 1 : 0));
        chk(bus_oe == 0 && bus_dout == 0, "R8 idle bus", bus_dout, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] g; logic o;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
        chk(wide_mode == 1, "R1 reset mode", wide_mode, 1);
        chk(bus_oe == 0 && bus_dout == 0, "R1 reset bus", bus_dout, 0);
        chk(n_iv + n_dv + n_rd == 0, "R1 no strobes", n_iv + n_dv + n_rd, 0);

        write_byte(1, 8'h3C, 3);          // R3 minimum strobe, data changes at fall
        write_byte(0, 8'h0F, 3);          // R3
        core_busy = 1; core_ac = 7'h55;
        read_byte(0, {1'b1, 7'h55});      // R6
        core_rd_data = 8'hA7;
        read_byte(1, 8'hA7);              // R7
        write_byte(0, 8'h28, 4);          // R5 to 4-bit
        chk(wide_mode == 0, "R5 now 4-bit", wide_mode, 0);
        write_byte(1, 8'h96, 4);          // R4
        core_busy = 0; core_ac = 7'h2B;
        read_byte(0, {1'b0, 7'h2B});      // R6
        core_rd_data = 8'h5E;
        read_byte(1, 8'h5E);              // R7
        write_byte(0, 8'h30, 4);          // R5 back to 8-bit
        chk(wide_mode == 1, "R5 back to 8-bit", wide_mode, 1);

        // R10: reset between nibbles
        write_byte(0, 8'h20, 4);
        xfer(1, 0, 8'hF0, 4, g, o);
        @(negedge clk); rst_n = 0; m_wide = 1;
        repeat (2) @(negedge clk); rst_n = 1;
        repeat (2) @(negedge clk);
        chk(wide_mode == 1, "R10 reset mode", wide_mode, 1);
        write_byte(0, 8'h20, 4);
        write_byte(1, 8'hA5, 4);          // R10 first nibble after reset is high

        for (int i = 0; i < 60; i++) begin
            int k = $urandom_range(0, 3);
            logic [7:0] b = 8'($urandom);
            case (k)
                0: write_byte(0, b, $urandom_range(3, 6));
                1: write_byte(1, b, $urandom_range(3, 6));
                2: begin
                    core_busy = 1'($urandom); core_ac = 7'($urandom);
                    read_byte(0, {core_busy, core_ac});
                end
                default: begin
                    core_rd_data = b;
                    read_byte(1, b);
                end
            endcase
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule